// File: doc/BRIEF.md
# Transaction Begin Nesting Controller

This block follows a processor core as it enters and leaves nested hardware transactions. Each cycle the decoder may present a begin, an end or an abort event. A begin also carries the current instruction pointer, the execution mode (64-bit or 32-bit), the operand size (16 or 32) and a relative offset. The block keeps a nesting depth and an active flag.

Only the outermost begin computes and latches a fallback target. The target is the instruction pointer plus the offset, extended to the width of the mode. It is never cut down to 16 bits. The outermost begin also pulses a checkpoint request, which asks the core to record its register state and start tracking memory. If the target is illegal, the block raises a general-protection fault with error code zero and leaves its state untouched. A target is illegal when it is non-canonical in 64-bit mode, or when it lies above the code-segment limit in 32-bit mode.

On an abort, the block pulses a restore request and a redirect to the latched target, and it returns to idle in the same cycle. A begin that would exceed the configured maximum depth is treated as an abort. When the last end brings the depth back to zero, the block emits a commit pulse.

Top module: `txn_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, depth_o is 0 and active_o, checkpoint_o, commit_o, gp_fault_o, restore_o and redirect_o are all 0.
- R2: A begin taken while depth_o is below MAX_DEPTH increments depth_o by one, visible on the clock edge that samples the begin.
- R3: A legal begin at depth 0 sets active_o, makes depth_o 1, pulses checkpoint_o for one cycle and latches the fallback target. A begin at depth 1 or more leaves the latched target unchanged, which is observed at the next abort.
- R4: In 64-bit mode (long_mode_i=1) the target is ip_i plus the offset sign-extended to 64 bits. When opsz16_i=1 the offset is offset_i[15:0] and offset_i[31:16] is ignored. When opsz16_i=0 the offset is offset_i[31:0]. The sum is not truncated to 16 bits.
- R5: In 32-bit mode (long_mode_i=0) the target is ip_i[31:0] plus the offset, modulo 2^32, with bits 63:32 zero. When opsz16_i=1 the offset is offset_i[15:0] sign-extended to 32 bits, and the sum is not truncated to 16 bits.
- R6: In 64-bit mode, a target whose bits 63 to 47 are not all equal makes the outermost begin pulse gp_fault_o for one cycle with gp_code_o = 0. It produces no checkpoint_o pulse and leaves depth_o at 0 and active_o at 0.
- R7: In 32-bit mode, a target greater than seg_limit_i faults in the same way as R6. A target equal to seg_limit_i is legal.
- R8: abort_i while active_o=1 pulses restore_o and redirect_o for one cycle, with redirect_addr_o equal to the latched target. In that same cycle depth_o reads 0 and active_o reads 0.
- R9: A begin while depth_o equals MAX_DEPTH does not increment the depth and behaves as an abort (R8).
- R10: An end while depth_o is nonzero decrements depth_o. When depth_o goes from 1 to 0, active_o clears and commit_o pulses for one cycle.
- R11: abort_i or end_i while depth_o is 0 has no effect: no restore_o, no redirect_o, no commit_o, and depth_o stays 0.
- R12: When events coincide while active, abort_i wins over begin and end. A begin and an end in the same cycle act as a begin alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| begin_i | input | 1 | Transaction-begin event |
| end_i | input | 1 | Transaction-end event |
| abort_i | input | 1 | Abort event |
| ip_i | input | 64 | Instruction pointer following the begin |
| long_mode_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| opsz16_i | input | 1 | 1 = 16-bit operand size |
| offset_i | input | 32 | Relative offset field |
| seg_limit_i | input | 32 | Code-segment limit for 32-bit mode |
| depth_o | output | DEPTH_W | Current nesting depth |
| active_o | output | 1 | Transaction active |
| checkpoint_o | output | 1 | Pulse: record registers and start memory tracking |
| commit_o | output | 1 | Pulse: outermost transaction ended |
| gp_fault_o | output | 1 | Pulse: general-protection fault on begin |
| gp_code_o | output | 16 | Fault error code |
| restore_o | output | 1 | Pulse: restore state to the outermost begin |
| redirect_o | output | 1 | Pulse: redirect execution |
| redirect_addr_o | output | 64 | Redirect target, valid with redirect_o |

## Verification
Every result is registered once. An event sampled at a rising edge shows up on depth_o, active_o and every pulse output just after that same edge, and it stays until the next edge. The bench drives events in the middle of a cycle, waits for one rising edge, and samples 2 ns later. In that window each pulse is checked both where it is expected and where it must stay low. The latched target is checked only at the port: after an abort, redirect_addr_o is compared with constants worked out by hand for each mode, operand size, wrap-around and canonical-boundary case.

// File: rtl/txn_nest_pkg.sv
// Package: shared address type and the action code the event arbiter hands
// to the state registers. Assumes 64-bit addresses throughout.
package txn_nest_pkg;
    localparam int ADDR_W = 64;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_OUTER,
        ACT_INNER,
        ACT_FAULT,
        ACT_CLOSE,
        ACT_ABORT
    } act_e;
endpackage

// File: rtl/txn_target_calc.sv
// txn_target_calc: combinational fallback-target adder and legality test.
// The 16-bit offset variant is sign-extended, never truncated after the add.
// Assumes VA_BITS is between 32 and 64; at 64 every address is canonical.
module txn_target_calc
    import txn_nest_pkg::*;
#(
    parameter int VA_BITS = 48
) (
    input  addr_t       ip_i,
    input  logic        long_mode_i,
    input  logic        opsz16_i,
    input  logic [31:0] offset_i,
    input  logic [31:0] seg_limit_i,
    output addr_t       target_o,
    output logic        legal_o
);
    addr_t       off_wide;
    addr_t       sum_wide;
    logic [31:0] off_narrow;
    logic [31:0] sum_narrow;
    logic        canon;

    // Purpose: pick and extend the offset for both mode widths.
    always_comb begin
        off_wide   = opsz16_i ? {{48{offset_i[15]}}, offset_i[15:0]}
                              : {{32{offset_i[31]}}, offset_i};
        off_narrow = opsz16_i ? {{16{offset_i[15]}}, offset_i[15:0]} : offset_i;
        sum_wide   = ip_i + off_wide;
        sum_narrow = ip_i[31:0] + off_narrow;
    end

    generate
        if (VA_BITS >= 64) begin : g_flat_space
            assign canon = 1'b1;
        end else begin : g_canon_check
            logic [64-VA_BITS:0] upper;
            assign upper = sum_wide[63:VA_BITS-1];
            assign canon = (&upper) | ~(|upper);
        end
    endgenerate

    // Purpose: select the mode result and its legality rule.
    always_comb begin
        if (long_mode_i) begin
            target_o = sum_wide;
            legal_o  = canon;
        end else begin
            target_o = {32'h0, sum_narrow};
            legal_o  = (sum_narrow <= seg_limit_i);
        end
    end

    // R5: a 32-bit-mode target never has upper bits set
    always_comb begin
        if (!long_mode_i) begin
            p_narrow_upper_zero_r5: assert (target_o[63:32] == 32'h0);
        end
    end
endmodule

// File: rtl/txn_event_arb.sv
// txn_event_arb: turns raw begin/end/abort strobes plus the current depth
// and target legality into a single action. Priority: abort (or a begin at
// full depth) over begin over end. Events while idle other than begin drop.
module txn_event_arb
    import txn_nest_pkg::*;
#(
    parameter int MAX_DEPTH = 4,
    parameter int DEPTH_W   = 3
) (
    input  logic               open_i,
    input  logic               close_i,
    input  logic               abort_i,
    input  logic [DEPTH_W-1:0] depth_i,
    input  logic               legal_i,
    output act_e               act_o
);
    localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(MAX_DEPTH);

    logic busy;
    logic full;

    // Purpose: derive occupancy conditions.
    always_comb begin
        busy = (depth_i != '0);
        full = (depth_i == FULL);
    end

    // Purpose: prioritised action select.
    always_comb begin
        act_o = ACT_IDLE;
        if (busy && (abort_i || (open_i && full))) begin
            act_o = ACT_ABORT;
        end else if (open_i) begin
            if (!busy) begin
                act_o = legal_i ? ACT_OUTER : ACT_FAULT;
            end else begin
                act_o = ACT_INNER;
            end
        end else if (close_i && busy) begin
            act_o = ACT_CLOSE;
        end
    end

    // R9: an increment is never issued at full depth
    always_comb begin
        if (act_o == ACT_INNER) begin
            p_no_inner_at_full_r9: assert (depth_i < FULL);
        end
    end
endmodule

// File: rtl/txn_depth_ctr.sv
// txn_depth_ctr: nesting counter, active flag and commit pulse. Consumes
// the arbiter action; assumes the arbiter never asks for an increment at
// full depth or a decrement at zero.
module txn_depth_ctr
    import txn_nest_pkg::*;
#(
    parameter int MAX_DEPTH = 4,
    parameter int DEPTH_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  act_e               act_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               active_o,
    output logic               commit_o
);
    logic [DEPTH_W-1:0] depth_q;
    logic               active_q;
    logic               commit_q;

    // Purpose: update depth, active flag and commit pulse per action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q  <= '0;
            active_q <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            unique case (act_i)
                ACT_OUTER: begin
                    depth_q  <= DEPTH_W'(1);
                    active_q <= 1'b1;
                end
                ACT_INNER: depth_q <= depth_q + 1'b1;
                ACT_CLOSE: begin
                    depth_q <= depth_q - 1'b1;
                    if (depth_q == DEPTH_W'(1)) begin
                        active_q <= 1'b0;
                        commit_q <= 1'b1;
                    end
                end
                ACT_ABORT: begin
                    depth_q  <= '0;
                    active_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign depth_o  = depth_q;
    assign active_o = active_q;
    assign commit_o = commit_q;

    // R2: depth stays within the configured bound
    p_depth_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_W'(MAX_DEPTH));

    // R10: active flag agrees with a nonzero depth
    p_active_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        active_q == (depth_q != '0));

    // R10: commit only on the step from depth one to zero
    p_commit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> (depth_q == '0) && ($past(depth_q) == DEPTH_W'(1)));
endmodule

// File: rtl/txn_nest_ctrl.sv
// txn_nest_ctrl: top of the transaction nesting controller. Latches the
// fallback target on the outermost legal begin and registers every pulse
// output, so all results appear one edge after the sampled event.
// Assumes events are single-cycle strobes from the decoder.
module txn_nest_ctrl
    import txn_nest_pkg::*;
#(
    parameter int MAX_DEPTH = 4,
    parameter int VA_BITS   = 48,
    parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               begin_i,
    input  logic               end_i,
    input  logic               abort_i,
    input  logic [63:0]        ip_i,
    input  logic               long_mode_i,
    input  logic               opsz16_i,
    input  logic [31:0]        offset_i,
    input  logic [31:0]        seg_limit_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               active_o,
    output logic               checkpoint_o,
    output logic               commit_o,
    output logic               gp_fault_o,
    output logic [15:0]        gp_code_o,
    output logic               restore_o,
    output logic               redirect_o,
    output logic [63:0]        redirect_addr_o
);
    addr_t target_c;
    logic  legal_c;
    act_e  act_c;

    addr_t target_q;
    addr_t redir_addr_q;
    logic  ckpt_q;
    logic  fault_q;
    logic  restore_q;
    logic  redirect_q;

    txn_target_calc #(
        .VA_BITS(VA_BITS)
    ) u_calc (
        .ip_i       (ip_i),
        .long_mode_i(long_mode_i),
        .opsz16_i   (opsz16_i),
        .offset_i   (offset_i),
        .seg_limit_i(seg_limit_i),
        .target_o   (target_c),
        .legal_o    (legal_c)
    );

    txn_event_arb #(
        .MAX_DEPTH(MAX_DEPTH),
        .DEPTH_W  (DEPTH_W)
    ) u_arb (
        .open_i (begin_i),
        .close_i(end_i),
        .abort_i(abort_i),
        .depth_i(depth_o),
        .legal_i(legal_c),
        .act_o  (act_c)
    );

    txn_depth_ctr #(
        .MAX_DEPTH(MAX_DEPTH),
        .DEPTH_W  (DEPTH_W)
    ) u_depth (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_c),
        .depth_o (depth_o),
        .active_o(active_o),
        .commit_o(commit_o)
    );

    // Purpose: latch the fallback target on the outermost legal begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
        end else if (act_c == ACT_OUTER) begin
            target_q <= target_c;
        end
    end

    // Purpose: register checkpoint, fault, restore and redirect pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ckpt_q       <= 1'b0;
            fault_q      <= 1'b0;
            restore_q    <= 1'b0;
            redirect_q   <= 1'b0;
            redir_addr_q <= '0;
        end else begin
            ckpt_q     <= (act_c == ACT_OUTER);
            fault_q    <= (act_c == ACT_FAULT);
            restore_q  <= (act_c == ACT_ABORT);
            redirect_q <= (act_c == ACT_ABORT);
            if (act_c == ACT_ABORT) begin
                redir_addr_q <= target_q;
            end
        end
    end

    assign checkpoint_o    = ckpt_q;
    assign gp_fault_o      = fault_q;
    assign gp_code_o       = 16'h0000;
    assign restore_o       = restore_q;
    assign redirect_o      = redirect_q;
    assign redirect_addr_o = redir_addr_q;

    // R3: checkpoint pulse coincides with entry to depth one
    p_ckpt_outer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_q |-> active_o && (depth_o == DEPTH_W'(1)));

    // R3: latched target holds while nested deeper than one
    p_inner_keeps_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_o > DEPTH_W'(1)) |-> $stable(target_q));

    // R6: a fault leaves the controller idle with no checkpoint
    p_fault_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> !active_o && (depth_o == '0) && !ckpt_q);

    // R8: redirect arrives with restore and an idle controller
    p_redirect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_q |-> restore_q && !active_o && (depth_o == '0));

    // R8: redirect address is the target latched before the abort
    p_redirect_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_q |-> (redir_addr_q == $past(target_q)));
endmodule

// File: tb/test_txn_nest_ctrl.sv
module test_txn_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        begin_i = 1'b0, end_i = 1'b0, abort_i = 1'b0;
    logic [63:0] ip_i = '0;
    logic        long_mode_i = 1'b1, opsz16_i = 1'b0;
    logic [31:0] offset_i = '0, seg_limit_i = 32'hFFFF_FFFF;
    logic [2:0]  depth_o;
    logic        active_o, checkpoint_o, commit_o, gp_fault_o;
    logic [15:0] gp_code_o;
    logic        restore_o, redirect_o;
    logic [63:0] redirect_addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txn_nest_ctrl i_txn_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .end_i(end_i),
        .abort_i(abort_i), .ip_i(ip_i), .long_mode_i(long_mode_i),
        .opsz16_i(opsz16_i), .offset_i(offset_i), .seg_limit_i(seg_limit_i),
        .depth_o(depth_o), .active_o(active_o), .checkpoint_o(checkpoint_o),
        .commit_o(commit_o), .gp_fault_o(gp_fault_o), .gp_code_o(gp_code_o),
        .restore_o(restore_o), .redirect_o(redirect_o),
        .redirect_addr_o(redirect_addr_o)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one event mid-cycle, let one edge take it, sample 2 ns later.
    task automatic ev(logic b, logic e, logic a, logic [63:0] ip, logic lm,
                      logic o16, logic [31:0] off, logic [31:0] lim);
        begin_i = b; end_i = e; abort_i = a; ip_i = ip;
        long_mode_i = lm; opsz16_i = o16; offset_i = off; seg_limit_i = lim;
        @(posedge clk);
        #2;
        begin_i = 1'b0; end_i = 1'b0; abort_i = 1'b0;
    endtask

    task automatic open64(logic [63:0] ip, logic o16, logic [31:0] off);
        ev(1, 0, 0, ip, 1, o16, off, 32'hFFFF_FFFF);
    endtask

    task automatic do_abort();
        ev(0, 0, 1, '0, 1, 0, '0, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        chk("R1 depth", depth_o, 0);
        chk("R1 pulses", {active_o, checkpoint_o, commit_o, gp_fault_o, restore_o, redirect_o}, 0);
    endtask

    task automatic t_long32();
        open64(64'h0000_0000_4000_1000, 0, 32'hFFFF_FF00);
        chk("R3 checkpoint", checkpoint_o, 1);
        chk("R3 active", active_o, 1);
        chk("R2 depth", depth_o, 1);
        do_abort();
        chk("R8 restore/redirect", {restore_o, redirect_o}, 2'b11);
        chk("R4 addr rel32", redirect_addr_o, 64'h0000_0000_4000_0F00);
        chk("R8 idle", {active_o, depth_o}, 0);
    endtask

    task automatic t_long16_nested();
        open64(64'h0000_1234_5678_FFF0, 1, 32'hABCD_0020);
        open64(64'h0000_0000_0000_9999, 0, 32'h0000_0100);
        chk("R2 depth two", depth_o, 2);
        chk("R3 no inner checkpoint", checkpoint_o, 0);
        do_abort();
        chk("R4 R3 addr outer kept", redirect_addr_o, 64'h0000_1234_5679_0010);
    endtask

    task automatic t_narrow();
        ev(1, 0, 0, 64'hFFFF_FFFF_0001_FFF0, 0, 1, 32'h0000_0020, 32'hFFFF_FFFF);
        do_abort();
        chk("R5 rel16 no trunc", redirect_addr_o, 64'h0000_0000_0002_0010);
        ev(1, 0, 0, 64'h0000_0000_0000_1000, 0, 1, 32'h0000_FFF0, 32'hFFFF_FFFF);
        do_abort();
        chk("R5 rel16 negative", redirect_addr_o, 64'h0000_0000_0000_0FF0);
        ev(1, 0, 0, 64'h0000_0000_FFFF_FF00, 0, 0, 32'h0000_0200, 32'hFFFF_FFFF);
        do_abort();
        chk("R5 rel32 wrap", redirect_addr_o, 64'h0000_0000_0000_0100);
    endtask

    task automatic t_canon();
        open64(64'h0000_7FFF_FFFF_FF00, 0, 32'h0000_0200);
        chk("R6 fault pos", gp_fault_o, 1);
        chk("R6 code", gp_code_o, 0);
        chk("R6 state kept", {checkpoint_o, active_o, depth_o}, 0);
        open64(64'hFFFF_8000_0000_0100, 0, 32'hFFFF_FE00);
        chk("R6 fault neg", gp_fault_o, 1);
        chk("R6 depth", depth_o, 0);
        open64(64'hFFFF_8000_0000_0300, 0, 32'hFFFF_FE00);
        chk("R6 legal high", {gp_fault_o, checkpoint_o}, 2'b01);
        do_abort();
        chk("R6 legal addr", redirect_addr_o, 64'hFFFF_8000_0000_0100);
    endtask

    task automatic t_limit();
        ev(1, 0, 0, 64'h0000_0000_0000_FFF0, 0, 0, 32'h0000_0010, 32'h0000_FFFF);
        chk("R7 over limit fault", {gp_fault_o, active_o}, 2'b10);
        ev(1, 0, 0, 64'h0000_0000_0000_FFE0, 0, 0, 32'h0000_001F, 32'h0000_FFFF);
        chk("R7 at limit legal", {gp_fault_o, checkpoint_o}, 2'b01);
        do_abort();
        chk("R7 addr", redirect_addr_o, 64'h0000_0000_0000_FFFF);
    endtask

    task automatic t_overflow();
        open64(64'h0000_0000_0000_5000, 0, 32'h0000_0040);
        for (int k = 0; k < 3; k++) open64(64'h0000_0000_0000_7000, 0, 0);
        chk("R2 depth max", depth_o, 4);
        open64(64'h0000_0000_0000_7000, 0, 0);
        chk("R9 overflow abort", {restore_o, redirect_o}, 2'b11);
        chk("R9 depth cleared", depth_o, 0);
        chk("R9 addr", redirect_addr_o, 64'h0000_0000_0000_5040);
    endtask

    task automatic t_close();
        open64(64'h0000_0000_0000_1000, 0, 0);
        open64(64'h0000_0000_0000_1000, 0, 0);
        ev(0, 1, 0, '0, 1, 0, 0, 32'hFFFF_FFFF);
        chk("R10 inner end", {commit_o, active_o, depth_o}, {1'b0, 1'b1, 3'd1});
        ev(0, 1, 0, '0, 1, 0, 0, 32'hFFFF_FFFF);
        chk("R10 outer end", {commit_o, active_o, depth_o}, {1'b1, 1'b0, 3'd0});
        @(posedge clk); #2;
        chk("R10 commit one cycle", commit_o, 0);
    endtask

    task automatic t_idle();
        do_abort();
        chk("R11 idle abort", {restore_o, redirect_o, depth_o}, 0);
        ev(0, 1, 0, '0, 1, 0, 0, 32'hFFFF_FFFF);
        chk("R11 idle end", {commit_o, depth_o}, 0);
    endtask

    task automatic t_priority();
        open64(64'h0000_0000_0000_2000, 0, 32'h0000_0008);
        ev(1, 1, 1, 64'h0000_0000_0000_3000, 1, 0, 0, 32'hFFFF_FFFF);
        chk("R12 abort wins", {redirect_o, depth_o}, {1'b1, 3'd0});
        chk("R12 addr", redirect_addr_o, 64'h0000_0000_0000_2008);
        open64(64'h0000_0000_0000_2000, 0, 0);
        ev(1, 1, 0, 64'h0000_0000_0000_3000, 1, 0, 0, 32'hFFFF_FFFF);
        chk("R12 begin over end", {commit_o, depth_o}, {1'b0, 3'd2});
        do_abort();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_long32();
        t_long16_nested();
        t_narrow();
        t_canon();
        t_limit();
        t_overflow();
        t_close();
        t_idle();
        t_priority();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule